// File: doc/BRIEF.md
# Voltage-ID Soft-Start Ramp Sequencer

This block drives the reference code of a voltage regulator's DAC from zero up to a requested output voltage. It also keeps the code tracking the targets that arrive later. Once enabled, it works through four intervals in sequence:

1. A flat delay.
2. A ramp up to a boot code, taken from an input.
3. A hold at the boot code.
4. A second ramp to the voltage-ID target carried by the most recent valid command.

Every change to the DAC code is a single 5 mV step. The time between steps comes from the clock frequency and the selected slew rate. Codes below 250 mV step more slowly, which limits inrush current.

A ready flag marks the end of soft-start. It drops on a fault, on disable, on power-on reset, or on a voltage-ID off-code; a configuration byte can keep ready high through an off-code. The block also outputs the overvoltage trip threshold. That threshold is a fixed level until soft-start completes, and after that it follows the DAC code at a fixed offset. All codes are in 5 mV units.

Top module: `vid_softstart`

## Requirements
- R1: After en_i rises with por_i low and no fault present, dac_code_o stays 0 for DELAY_NS worth of clock cycles and only then starts to ramp.
- R2: Every change of dac_code_o, other than a clear to 0, is exactly one code (5 mV). In the ramp to the boot code, the step spacing at codes ≥ 50 is BOOT_DIV times the fast spacing, where the fast spacing is CLK_MHZ*5000/FAST_UVUS cycles.
- R3: While the code before a step is below 50 (250 mV), the spacing of that step is LOW_MULT times the normal spacing.
- R4: Once the boot code is reached with no command yet taken, the DAC holds it for HOLD_NS worth of cycles. A command arriving during the hold does not move the DAC until the hold has ended.
- R5: The ramp to a commanded target uses the fast spacing when vid_slow_i=0 and the slow spacing (CLK_MHZ*5000/SLOW_UVUS) when vid_slow_i=1. ready_o rises once dac_code_o equals the target.
- R6: A valid command that arrives before the boot code is reached redirects the ramp to the command's code. The hold is then skipped, and ready_o rises on arrival at the commanded code.
- R7: A strobe whose code is above MAX_CODE has no effect on the DAC target.
- R8: ocp_i, ovp_flt_i, por_i or a low en_i force ready_o low and dac_code_o to 0 on the next clock. A fault stays latched until en_i goes low or por_i is asserted.
- R9: A valid strobe with code 0 works as an off-code. With vr_cfg_i = 8'h01 after soft-start, ready_o stays high and the DAC ramps to 0. Otherwise ready_o drops and dac_code_o clears to 0 until a nonzero command restarts the ramp.
- R10: ovp_thr_o is 460 (2.3 V) while ready_o is low. It is dac_code_o + 36 (about 179 mV above the DAC) while ready_o is high.
- R11: After soft-start, each new valid command moves the DAC to its code one step at a time at the command's rate, and ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Regulator enable |
| por_i | input | 1 | Power-on reset, active high |
| ocp_i | input | 1 | Overcurrent fault flag |
| ovp_flt_i | input | 1 | Overvoltage fault flag |
| vid_vld_i | input | 1 | One-cycle strobe: a new voltage-ID command is present |
| vid_code_i | input | CODE_W | Commanded code, 5 mV units, 0 = off |
| vid_slow_i | input | 1 | Rate select of the command: 0 fast, 1 slow |
| vr_cfg_i | input | 8 | Configuration byte; 8'h01 keeps ready through an off-code |
| boot_code_i | input | CODE_W | Boot code for the first ramp |
| dac_code_o | output | CODE_W | DAC reference code, 5 mV units |
| ready_o | output | 1 | Soft-start done and output regulated |
| ovp_thr_o | output | CODE_W+1 | Active overvoltage trip threshold code |

## Verification
The sequencer is first driven through a full soft-start with no early command. The step spacing is timed below 250 mV and above it, which separates the low-segment multiplier from the quarter-rate boot spacing. A command sent during the hold shows whether the hold really delays it, and timing the ramp that follows separates the fast rate from the slow one.

A second start receives its command in the middle of the boot ramp. Landing on the commanded code rather than the boot code shows that the retarget works.

Random commands in the tracking phase mix valid codes, out-of-range codes and both rates. The out-of-range codes must leave the settled code unchanged. Off-codes with each configuration value, a one-cycle overcurrent pulse and power-on reset then tell the keep-ready path apart from the drop-and-clear path, and confirm that a fault stays latched.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DELAY = 3'd1,
    ST_RAMP1 = 3'd2,
    ST_HOLD  = 3'd3,
    ST_RAMP2 = 3'd4,
    ST_RUN   = 3'd5,
    ST_PARK  = 3'd6
  } ss_state_e;

  typedef enum logic [1:0] {
    RT_BOOT = 2'd0,
    RT_FAST = 2'd1,
    RT_SLOW = 2'd2
  } ss_rate_e;

  // Cycles per 5 mV step for a slew rate given in microvolts per microsecond.
  function automatic int unsigned step_cycles(input int unsigned clk_mhz,
                                              input int unsigned uv_per_us);
    int unsigned q;
    q = (clk_mhz * 5000) / uv_per_us;
    return (q == 0) ? 1 : q;
  endfunction

  // Millivolts to the nearest 5 mV code.
  function automatic int unsigned mv_to_code(input int unsigned mv);
    return (mv + 2) / 5;
  endfunction

  // Nanoseconds to clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                               input int unsigned ns);
    longint unsigned q;
    q = (longint'(ns) * longint'(clk_mhz)) / 1000;
    return (q == 0) ? 1 : int'(q);
  endfunction

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W   = 9,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned FAST_CYC = 62,
  parameter int unsigned SLOW_CYC = 250,
  parameter int unsigned BOOT_CYC = 248,
  parameter int unsigned LOW_CODE = 50,
  parameter int unsigned LOW_MULT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  ss_rate_e          rate_i,
  input  logic [CODE_W-1:0] dac_i,
  output logic              step_o
);

  localparam int unsigned FAST_LOW = FAST_CYC * LOW_MULT;
  localparam int unsigned SLOW_LOW = SLOW_CYC * LOW_MULT;
  localparam int unsigned BOOT_LOW = BOOT_CYC * LOW_MULT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             low_seg;

  assign low_seg = (dac_i < CODE_W'(LOW_CODE));

  always_comb begin
    unique case (rate_i)
      RT_FAST: last = low_seg ? CNT_W'(FAST_LOW - 1) : CNT_W'(FAST_CYC - 1);
      RT_SLOW: last = low_seg ? CNT_W'(SLOW_LOW - 1) : CNT_W'(SLOW_CYC - 1);
      default: last = low_seg ? CNT_W'(BOOT_LOW - 1) : CNT_W'(BOOT_CYC - 1);
    endcase
  end

  assign step_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ss_dac_ramp.sv
module ss_dac_ramp #(
  parameter int unsigned CODE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] dac_o,
  output logic              at_tgt_o
);

  logic [CODE_W-1:0] dac_q;

  assign dac_o    = dac_q;
  assign at_tgt_o = (dac_q == tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dac_q <= '0;
    else if (clr_i)                   dac_q <= '0;
    else if (step_i && dac_q < tgt_i) dac_q <= dac_q + 1'b1;
    else if (step_i && dac_q > tgt_i) dac_q <= dac_q - 1'b1;
  end

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W    = 9,
  parameter int unsigned DELAY_CYC = 12500,
  parameter int unsigned HOLD_CYC  = 575000,
  parameter int unsigned MAX_CODE  = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              vid_vld_i,
  input  logic [CODE_W-1:0] vid_code_i,
  input  logic              vid_slow_i,
  input  logic              keep_rdy_i,
  input  logic [CODE_W-1:0] boot_code_i,
  input  logic              at_tgt_i,
  output ss_state_e         st_o,
  output logic [CODE_W-1:0] tgt_o,
  output ss_rate_e          rate_o,
  output logic              clr_o,
  output logic              run_o,
  output logic              vid_bad_o
);

  localparam int unsigned DCNT_W = $clog2(DELAY_CYC + 1);
  localparam int unsigned HCNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [DCNT_W-1:0] D_LAST = DCNT_W'(DELAY_CYC - 1);
  localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(HOLD_CYC - 1);

  ss_state_e         st_q, nxt;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  ss_rate_e          rate_q, rate_d;
  logic              have_q, have_d;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              vid_ok, vid_off, take;
  ss_rate_e          cmd_rate;

  assign vid_off   = vid_vld_i && (vid_code_i == '0);
  assign vid_bad_o = vid_vld_i && (vid_code_i > CODE_W'(MAX_CODE));
  assign vid_ok    = vid_vld_i && !vid_off && !vid_bad_o;
  assign cmd_rate  = vid_slow_i ? RT_SLOW : RT_FAST;

  always_comb begin
    nxt    = st_q;
    tgt_d  = tgt_q;
    rate_d = rate_q;
    have_d = have_q;
    dcnt_d = dcnt_q;
    hcnt_d = hcnt_q;
    take   = 1'b0;
    if (abort_i) begin
      nxt = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          nxt    = ST_DELAY;
          dcnt_d = '0;
          tgt_d  = boot_code_i;
          rate_d = RT_BOOT;
          have_d = 1'b0;
        end
        ST_DELAY: begin
          if (vid_off) nxt = ST_PARK;
          else begin
            take = vid_ok;
            if (dcnt_q == D_LAST) nxt = ST_RAMP1;
            else dcnt_d = dcnt_q + 1'b1;
          end
        end
        ST_RAMP1: begin
          if (vid_off) nxt = ST_PARK;
          else if (vid_ok) take = 1'b1;
          else if (at_tgt_i) begin
            nxt    = have_q ? ST_RUN : ST_HOLD;
            hcnt_d = '0;
          end
        end
        ST_HOLD: begin
          if (vid_off) nxt = ST_PARK;
          else begin
            take = vid_ok;
            if (hcnt_q != H_LAST) hcnt_d = hcnt_q + 1'b1;
            else if (have_q) nxt = ST_RAMP2;
          end
        end
        ST_RAMP2: begin
          if (vid_off) nxt = ST_PARK;
          else if (vid_ok) take = 1'b1;
          else if (at_tgt_i) nxt = ST_RUN;
        end
        ST_RUN: begin
          if (vid_ok) take = 1'b1;
          else if (vid_off) begin
            if (keep_rdy_i) begin
              tgt_d  = '0;
              rate_d = cmd_rate;
            end else begin
              nxt = ST_PARK;
            end
          end
        end
        ST_PARK: begin
          if (vid_ok) begin
            take = 1'b1;
            nxt  = ST_RAMP2;
          end
        end
        default: nxt = ST_OFF;
      endcase
      if (take) begin
        tgt_d  = vid_code_i;
        rate_d = cmd_rate;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      tgt_q  <= '0;
      rate_q <= RT_BOOT;
      have_q <= 1'b0;
      dcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      st_q   <= nxt;
      tgt_q  <= tgt_d;
      rate_q <= rate_d;
      have_q <= have_d;
      dcnt_q <= dcnt_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign st_o   = st_q;
  assign tgt_o  = tgt_q;
  assign rate_o = rate_q;
  assign clr_o  = (nxt == ST_OFF) || (nxt == ST_PARK);
  assign run_o  = ((st_q == ST_RAMP1) || (st_q == ST_RAMP2) || (st_q == ST_RUN)) && !at_tgt_i;

endmodule

// File: rtl/vid_softstart.sv
module vid_softstart
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned FAST_UVUS  = 10000,
  parameter int unsigned SLOW_UVUS  = 2500,
  parameter int unsigned BOOT_DIV   = 4,
  parameter int unsigned LOW_MV     = 250,
  parameter int unsigned LOW_MULT   = 4,
  parameter int unsigned DELAY_NS   = 100000,
  parameter int unsigned HOLD_NS    = 4600000,
  parameter int unsigned MAX_CODE   = 400,
  parameter int unsigned OVP_FIX_MV = 2300,
  parameter int unsigned OVP_OFS_MV = 179
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              por_i,
  input  logic              ocp_i,
  input  logic              ovp_flt_i,
  input  logic              vid_vld_i,
  input  logic [CODE_W-1:0] vid_code_i,
  input  logic              vid_slow_i,
  input  logic [7:0]        vr_cfg_i,
  input  logic [CODE_W-1:0] boot_code_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              ready_o,
  output logic [CODE_W:0]   ovp_thr_o
);

  localparam int unsigned FAST_CYC  = step_cycles(CLK_MHZ, FAST_UVUS);
  localparam int unsigned SLOW_CYC  = step_cycles(CLK_MHZ, SLOW_UVUS);
  localparam int unsigned BOOT_CYC  = FAST_CYC * BOOT_DIV;
  localparam int unsigned LOW_CODE  = mv_to_code(LOW_MV);
  localparam int unsigned OVP_FIX   = mv_to_code(OVP_FIX_MV);
  localparam int unsigned OVP_OFS   = mv_to_code(OVP_OFS_MV);
  localparam int unsigned MAX_BASE  = (BOOT_CYC > SLOW_CYC) ? BOOT_CYC : SLOW_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_BASE * LOW_MULT + 1);
  localparam int unsigned DELAY_CYC = ns_to_cycles(CLK_MHZ, DELAY_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(CLK_MHZ, HOLD_NS);

  // Named internal events, also observed by the bound checker.
  ss_state_e         st_w;
  ss_rate_e          rate_w;
  logic [CODE_W-1:0] tgt_w;
  logic              step_w, clr_w, run_w, at_tgt_w, vid_bad_w, abort_w;
  logic              flt_lat_q;
  logic [CODE_W-1:0] dac_w;

  assign abort_w = !en_i || por_i || ocp_i || ovp_flt_i || flt_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_lat_q <= 1'b0;
    else         flt_lat_q <= (flt_lat_q || ocp_i || ovp_flt_i) && en_i && !por_i;
  end

  ss_seq_fsm #(
    .CODE_W   (CODE_W),
    .DELAY_CYC(DELAY_CYC),
    .HOLD_CYC (HOLD_CYC),
    .MAX_CODE (MAX_CODE)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort_w),
    .vid_vld_i  (vid_vld_i),
    .vid_code_i (vid_code_i),
    .vid_slow_i (vid_slow_i),
    .keep_rdy_i (vr_cfg_i == 8'h01),
    .boot_code_i(boot_code_i),
    .at_tgt_i   (at_tgt_w),
    .st_o       (st_w),
    .tgt_o      (tgt_w),
    .rate_o     (rate_w),
    .clr_o      (clr_w),
    .run_o      (run_w),
    .vid_bad_o  (vid_bad_w)
  );

  ss_step_timer #(
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .FAST_CYC(FAST_CYC),
    .SLOW_CYC(SLOW_CYC),
    .BOOT_CYC(BOOT_CYC),
    .LOW_CODE(LOW_CODE),
    .LOW_MULT(LOW_MULT)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_w),
    .rate_i(rate_w),
    .dac_i (dac_w),
    .step_o(step_w)
  );

  ss_dac_ramp #(
    .CODE_W(CODE_W)
  ) u_dac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_w),
    .step_i  (step_w),
    .tgt_i   (tgt_w),
    .dac_o   (dac_w),
    .at_tgt_o(at_tgt_w)
  );

  assign dac_code_o = dac_w;
  assign ready_o    = (st_w == ST_RUN);
  assign ovp_thr_o  = ready_o ? ({1'b0, dac_w} + (CODE_W + 1)'(OVP_OFS))
                              : (CODE_W + 1)'(OVP_FIX);

endmodule

// File: rtl/vid_softstart_chk.sv
module vid_softstart_chk
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W  = 9,
  parameter int unsigned OVP_FIX = 460
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              por_i,
  input logic              ocp_i,
  input logic              ovp_flt_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              ready_o,
  input logic [CODE_W:0]   ovp_thr_o,
  input ss_state_e         st_i,
  input logic [CODE_W-1:0] tgt_i,
  input logic              vid_bad_i
);

  // R1: the DAC stays at zero through the initial delay
  a_r1_delay_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DELAY) |-> (dac_code_o == '0));

  // R2: each move is a single code, except a clear to zero
  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac_code_o != $past(dac_code_o)) && (dac_code_o != '0)) |->
      ((dac_code_o == $past(dac_code_o) + CODE_W'(1)) ||
       (dac_code_o == $past(dac_code_o) - CODE_W'(1))));

  // R4: no movement while holding
  a_r4_hold_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_HOLD) && ($past(st_i) == ST_HOLD)) |-> $stable(dac_code_o));

  // R5: ready rises only with the DAC on its target
  a_r5_ready_on_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (dac_code_o == tgt_i));

  // R7: an out-of-range code leaves the target alone
  a_r7_bad_code_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_bad_i && (st_i != ST_OFF)) |=> $stable(tgt_i));

  // R8: shutdown causes drop ready and clear the DAC on the next clock
  a_r8_abort_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || !en_i || ocp_i || ovp_flt_i) |=> (!ready_o && (dac_code_o == '0)));

  // R9: parked after an off-code means low and not ready
  a_r9_park_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PARK) |-> (!ready_o && (dac_code_o == '0)));

  // R10: fixed threshold throughout the delay interval
  a_r10_ovp_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DELAY) |-> (ovp_thr_o == (CODE_W + 1)'(OVP_FIX)));

endmodule

bind vid_softstart vid_softstart_chk #(
  .CODE_W (CODE_W),
  .OVP_FIX(OVP_FIX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .por_i     (por_i),
  .ocp_i     (ocp_i),
  .ovp_flt_i (ovp_flt_i),
  .dac_code_o(dac_code_o),
  .ready_o   (ready_o),
  .ovp_thr_o (ovp_thr_o),
  .st_i      (st_w),
  .tgt_i     (tgt_w),
  .vid_bad_i (vid_bad_w)
);

// File: tb/sim_vid_softstart.sv
module sim_vid_softstart;

  // Bench view of the timing: 125 MHz clock, 5 cycles per fast step,
  // 20 per slow step, boot spacing 4x fast, doubling below code 50.
  localparam int CW       = 9;
  localparam int T_FAST   = 5;
  localparam int T_SLOW   = 20;
  localparam int T_BOOT   = 20;
  localparam int LOW_C    = 50;
  localparam int DLY_CYC  = 30;
  localparam int HOLD_CYC = 100;
  localparam int OVP_FIX  = 460;
  localparam int OVP_OFS  = 36;
  localparam int MAXC     = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, por = 1'b0, ocp = 1'b0, ovpf = 1'b0;
  logic          vld = 1'b0, slow = 1'b0;
  logic [CW-1:0] code = '0;
  logic [7:0]    cfg = 8'h00;
  logic [CW-1:0] boot = CW'(60);
  logic [CW-1:0] dac;
  logic          rdy;
  logic [CW:0]   ovp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vid_softstart #(
    .CODE_W(CW), .CLK_MHZ(125), .FAST_UVUS(125000), .SLOW_UVUS(31250),
    .BOOT_DIV(4), .LOW_MV(250), .LOW_MULT(2), .DELAY_NS(240), .HOLD_NS(800),
    .MAX_CODE(MAXC), .OVP_FIX_MV(2300), .OVP_OFS_MV(179)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .por_i(por), .ocp_i(ocp),
    .ovp_flt_i(ovpf), .vid_vld_i(vld), .vid_code_i(code), .vid_slow_i(slow),
    .vr_cfg_i(cfg), .boot_code_i(boot), .dac_code_o(dac), .ready_o(rdy),
    .ovp_thr_o(ovp)
  );

  // rate: 0 boot, 1 fast, 2 slow
  function automatic int exp_gap(input int v, input int rate);
    int b;
    b = (rate == 1) ? T_FAST : ((rate == 2) ? T_SLOW : T_BOOT);
    return (v < LOW_C) ? 2 * b : b;
  endfunction

  function automatic int exp_ovp(input int d, input bit r);
    return r ? d + OVP_OFS : OVP_FIX;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int c, input bit s);
    @(negedge clk);
    vld = 1'b1; code = CW'(c); slow = s;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic wait_change(input int limit, output bit ok);
    logic [CW-1:0] v0;
    v0 = dac; ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (dac != v0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_dac(input int val, input int limit, output bit ok);
    ok = (int'(dac) == val);
    for (int i = 0; i < limit && !ok; i++) begin
      @(negedge clk);
      ok = (int'(dac) == val);
    end
  endtask

  task automatic wait_rdy(input int limit, output bit ok);
    ok = rdy;
    for (int i = 0; i < limit && !ok; i++) begin
      @(negedge clk);
      ok = rdy;
    end
  endtask

  // Time between two consecutive steps against the expected spacing.
  task automatic measure_gap(input int rate, input string req);
    bit ok;
    int v, n;
    wait_change(2000, ok);
    v = int'(dac);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (int'(dac) != v) break;
    end
    chk(n == exp_gap(v, rate), req, n, exp_gap(v, rate));
  endtask

  initial begin : wdog
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit ok;
    int expv, c, held;
    bit s;
    void'($urandom(32'd1234));
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R10 / R8: reset state
    chk(dac == 0, "R8 reset dac", int'(dac), 0);
    chk(!rdy, "R8 reset ready", int'(rdy), 0);
    chk(int'(ovp) == OVP_FIX, "R10 reset ovp", int'(ovp), OVP_FIX);

    // First soft-start, no early command
    en = 1'b1;
    cyc(DLY_CYC - 1);
    chk(dac == 0, "R1 delay flat", int'(dac), 0);
    chk(int'(ovp) == OVP_FIX, "R10 ovp in delay", int'(ovp), OVP_FIX);
    measure_gap(0, "R3 low boot gap");
    wait_dac(55, 3000, ok);
    measure_gap(0, "R2 boot gap");
    wait_dac(60, 1000, ok);
    chk(ok, "R2 boot reached", int'(dac), 60);
    cyc(3);
    send(100, 1'b0);
    held = 1;
    for (int i = 0; i < HOLD_CYC - 10; i++) begin
      @(negedge clk);
      if (dac != CW'(60)) held = 0;
    end
    chk(held == 1 && !rdy, "R4 hold", int'(dac), 60);
    measure_gap(1, "R5 fast gap");
    wait_rdy(1000, ok);
    chk(ok && dac == CW'(100), "R5 ready at target", int'(dac), 100);
    chk(int'(ovp) == exp_ovp(100, 1'b1), "R10 ovp tracking", int'(ovp), exp_ovp(100, 1'b1));

    // Tracking phase
    send(200, 1'b1);
    measure_gap(2, "R11 slow gap");
    wait_dac(200, 4000, ok);
    chk(ok && rdy, "R11 tracked", int'(dac), 200);
    send(450, 1'b0);
    cyc(60);
    chk(dac == CW'(200), "R7 bad code ignored", int'(dac), 200);

    expv = 200;
    for (int k = 0; k < 10; k++) begin
      c = int'($urandom_range(460, 51));
      s = 1'($urandom_range(1, 0));
      send(c, s);
      if (c <= MAXC) expv = c;
      wait_dac(expv, 12000, ok);
      cyc(40);
      chk(int'(dac) == expv && rdy, (c <= MAXC) ? "R11 random" : "R7 random",
          int'(dac), expv);
      chk(int'(ovp) == exp_ovp(expv, 1'b1), "R10 random ovp", int'(ovp),
          exp_ovp(expv, 1'b1));
    end

    // Off-code, keep-ready configuration
    cfg = 8'h01;
    send(0, 1'b0);
    cyc(4);
    chk(rdy, "R9 keep ready", int'(rdy), 1);
    wait_dac(0, 6000, ok);
    chk(ok && rdy, "R9 ramp to zero", int'(dac), 0);
    chk(int'(ovp) == OVP_OFS, "R10 ovp at zero", int'(ovp), OVP_OFS);
    send(80, 1'b0);
    wait_dac(80, 2000, ok);
    chk(ok && rdy, "R11 back up", int'(dac), 80);

    // Off-code, default configuration
    cfg = 8'h00;
    send(0, 1'b0);
    @(negedge clk);
    chk(!rdy && dac == 0, "R9 off drop", int'(dac), 0);
    chk(int'(ovp) == OVP_FIX, "R10 ovp after off", int'(ovp), OVP_FIX);
    send(70, 1'b1);
    wait_rdy(3000, ok);
    chk(ok && dac == CW'(70), "R9 restart after off", int'(dac), 70);

    // Overcurrent pulse, latched
    @(negedge clk);
    ocp = 1'b1;
    @(negedge clk);
    ocp = 1'b0;
    chk(!rdy && dac == 0, "R8 ocp drop", int'(dac), 0);
    cyc(200);
    chk(!rdy && dac == 0, "R8 fault latched", int'(dac), 0);

    // Restart with a command during the boot ramp
    en = 1'b0;
    cyc(2);
    en = 1'b1;
    wait_change(2000, ok);
    send(30, 1'b0);
    wait_rdy(2000, ok);
    chk(ok && dac == CW'(30), "R6 retarget", int'(dac), 30);

    // Power-on reset
    @(negedge clk);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    chk(!rdy && dac == 0, "R8 por drop", int'(dac), 0);
    cyc(5);
    chk(dac == 0 && int'(ovp) == OVP_FIX, "R1 restart delay", int'(dac), 0);

    // Overvoltage flag
    wait_rdy(5000, ok);
    ovpf = 1'b1;
    @(negedge clk);
    chk(!rdy && dac == 0, "R8 ovp drop", int'(dac), 0);
    ovpf = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule